// File: doc/BRIEF.md
# Pixel Overlay and Luminance Bar Mixer

This block sits in a video pixel path just after input decoding. For each valid pixel it either passes the incoming three-component pixel through, or replaces it with one of two internally generated colours. The first is a 3-bit title graphic colour, with one bit each for red, green and blue. It is applied per pixel when a per-pixel overlay enable is high. The second is a test pattern of vertical grey bars that step upward in brightness from left to right. When the bar enable is set, the pattern covers the whole active picture.

The pixel stream can be YCbCr or RGB, and a colour-space select input says which. Replacement colours are produced in that same space, so the output colour space always matches the input. Lane 0 carries Y or G, lane 1 carries Cb or B, and lane 2 carries Cr or R. Scan type does not matter: the block works on one pixel at a time and uses only the horizontal position and the active flag. Every output is registered exactly once, so data and its qualifying flags leave the block together.

Top module: `ovl_cbar_mixer`

## Requirements
- R1: While reset is held and until the first valid pixel after reset, out_valid, out_active, out_hsync, out_vsync and all three output lanes are 0.
- R2: A pixel presented with in_valid=1 appears on the outputs after exactly one clock edge, with out_valid=1 and out_active, out_hsync and out_vsync equal to the input flags of that pixel.
- R3: A clock with in_valid=0 gives out_valid=0 on the next cycle. All output lanes and flags keep their previous values.
- R4: With in_active=1 and both enables low, the three input lanes pass to the output unchanged.
- R5: With in_active=0 the three input lanes pass unchanged, whatever ovl_en and cbar_en are set to.
- R6: RGB overlay (csel_rgb=1, ovl_en=1, in_active=1, cbar_en=0): ovl_rgb bit 2 drives lane 2 (R), bit 1 drives lane 0 (G) and bit 0 drives lane 1 (B). Each lane is 940 when its bit is set and 64 when it is clear.
- R7: YCbCr overlay (csel_rgb=0) maps ovl_rgb codes 0..7 to Y/Cb/Cr as follows: black 64/512/512, blue 164/960/440, green 580/216/136, cyan 680/664/64, red 324/360/960, magenta 424/808/888, yellow 840/64/584, white 940/512/512.
- R8: The bar index is floor(in_hpos*4/act_width), limited to 3. When in_hpos is at or beyond act_width, or when act_width is 0, the index is 3.
- R9: Bar k (0..3) has level 283, 502, 721 or 940 (25/50/75/100 % of the 64..940 span). In YCbCr mode lane 0 carries the level and lanes 1 and 2 carry 512. In RGB mode all three lanes carry the level.
- R10: When cbar_en=1 on an active pixel, the bar colour is output and ovl_en and ovl_rgb have no effect.
- R11: Overlay enable and colour are taken from the same cycle as the pixel, so neighbouring pixels can switch independently between video and overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel qualifier |
| in_active | input | 1 | Pixel lies in the active picture |
| in_hsync | input | 1 | Horizontal sync flag, delayed with the pixel |
| in_vsync | input | 1 | Vertical sync flag, delayed with the pixel |
| in_hpos | input | HPOS_W | Pixel index within the active line |
| in_c0 | input | 10 | Y or G |
| in_c1 | input | 10 | Cb or B |
| in_c2 | input | 10 | Cr or R |
| ovl_rgb | input | 3 | Overlay colour {R,G,B} |
| ovl_en | input | 1 | Per-pixel overlay enable |
| cbar_en | input | 1 | Bar pattern enable |
| csel_rgb | input | 1 | 1 = RGB stream, 0 = YCbCr stream |
| act_width | input | HPOS_W | Active pixels per line |
| out_valid | output | 1 | Output qualifier |
| out_active | output | 1 | Delayed active flag |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_c0 | output | 10 | Y or G out |
| out_c1 | output | 10 | Cb or B out |
| out_c2 | output | 10 | Cr or R out |

## Verification
Plain video with both enables low shows that unchanged data reaches the output and that the sync flags arrive on the same cycle as the data. All eight overlay codes are driven in both colour spaces with the enable toggling pixel by pixel. This separates lane ordering, per-pixel gating and palette errors from each other. A bar sweep places pixels on each side of every region edge, beyond the line end and with a zero width, which exposes off-by-one and clamping faults. Blanking pixels with both enables high, bars with the overlay also enabled, and idle gaps check that blanking ignores the enables, that bars win over the overlay, and that outputs hold during gaps.

// File: rtl/ovl_cbar_pkg.sv
package ovl_cbar_pkg;
  localparam int PIX_W     = 10;
  localparam int LVL_BLACK = 64;
  localparam int LVL_WHITE = 940;
  localparam int LVL_MID   = 512;

  typedef struct packed {
    logic [PIX_W-1:0] c0;
    logic [PIX_W-1:0] c1;
    logic [PIX_W-1:0] c2;
  } pix_t;

  // grey level of step k out of nbars, spanning black..white
  function automatic int bar_level(input int k, input int nbars);
    return LVL_BLACK + ((LVL_WHITE - LVL_BLACK) * (k + 1)) / nbars;
  endfunction
endpackage

// File: rtl/ovl_palette.sv
module ovl_palette
  import ovl_cbar_pkg::*;
(
  input  logic [2:0] rgb,
  input  logic       csel_rgb,
  output pix_t       pix
);
  localparam logic [PIX_W-1:0] HI = PIX_W'(LVL_WHITE);
  localparam logic [PIX_W-1:0] LO = PIX_W'(LVL_BLACK);

  pix_t yuv_pix;

  always_comb begin
    case (rgb)
      3'd0:    yuv_pix = '{c0: 10'd64,  c1: 10'd512, c2: 10'd512};
      3'd1:    yuv_pix = '{c0: 10'd164, c1: 10'd960, c2: 10'd440};
      3'd2:    yuv_pix = '{c0: 10'd580, c1: 10'd216, c2: 10'd136};
      3'd3:    yuv_pix = '{c0: 10'd680, c1: 10'd664, c2: 10'd64};
      3'd4:    yuv_pix = '{c0: 10'd324, c1: 10'd360, c2: 10'd960};
      3'd5:    yuv_pix = '{c0: 10'd424, c1: 10'd808, c2: 10'd888};
      3'd6:    yuv_pix = '{c0: 10'd840, c1: 10'd64,  c2: 10'd584};
      default: yuv_pix = '{c0: 10'd940, c1: 10'd512, c2: 10'd512};
    endcase
  end

  always_comb begin
    if (csel_rgb) begin
      pix.c0 = rgb[1] ? HI : LO;
      pix.c1 = rgb[0] ? HI : LO;
      pix.c2 = rgb[2] ? HI : LO;
    end else begin
      pix = yuv_pix;
    end
  end
endmodule

// File: rtl/cbar_locator.sv
module cbar_locator #(
  parameter int HPOS_W   = 12,
  parameter int NUM_BARS = 4,
  localparam int IW      = $clog2(NUM_BARS),
  localparam int SW      = HPOS_W + IW
) (
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HPOS_W-1:0] act_width,
  output logic [IW-1:0]     bar_idx
);
  logic [NUM_BARS-2:0] past_edge;

  // pixel is at or right of edge k when hpos*N >= k*width
  for (genvar k = 1; k < NUM_BARS; k++) begin : g_edge
    assign past_edge[k-1] = (SW'(hpos) * SW'(NUM_BARS)) >= (SW'(k) * SW'(act_width));
  end

  always_comb begin
    bar_idx = '0;
    for (int i = 0; i < NUM_BARS - 1; i++) begin
      bar_idx = bar_idx + IW'(past_edge[i]);
    end
  end
endmodule

// File: rtl/cbar_shade.sv
module cbar_shade
  import ovl_cbar_pkg::*;
#(
  parameter int NUM_BARS = 4,
  localparam int IW      = $clog2(NUM_BARS)
) (
  input  logic [IW-1:0] bar_idx,
  input  logic          csel_rgb,
  output pix_t          pix
);
  logic [PIX_W-1:0] lvl_tab [NUM_BARS];
  logic [PIX_W-1:0] lvl;

  for (genvar k = 0; k < NUM_BARS; k++) begin : g_lvl
    assign lvl_tab[k] = PIX_W'(bar_level(k, NUM_BARS));
  end

  assign lvl = lvl_tab[bar_idx];

  always_comb begin
    pix.c0 = lvl;
    if (csel_rgb) begin
      pix.c1 = lvl;
      pix.c2 = lvl;
    end else begin
      pix.c1 = PIX_W'(LVL_MID);
      pix.c2 = PIX_W'(LVL_MID);
    end
  end
endmodule

// File: rtl/ovl_cbar_mixer.sv
module ovl_cbar_mixer
  import ovl_cbar_pkg::*;
#(
  parameter int HPOS_W   = 12,
  parameter int NUM_BARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_active,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic [HPOS_W-1:0] in_hpos,
  input  logic [9:0]        in_c0,
  input  logic [9:0]        in_c1,
  input  logic [9:0]        in_c2,
  input  logic [2:0]        ovl_rgb,
  input  logic              ovl_en,
  input  logic              cbar_en,
  input  logic              csel_rgb,
  input  logic [HPOS_W-1:0] act_width,
  output logic              out_valid,
  output logic              out_active,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic [9:0]        out_c0,
  output logic [9:0]        out_c1,
  output logic [9:0]        out_c2
);
  localparam int IW = $clog2(NUM_BARS);

  // reset: asserted at once, released after two clock edges
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pix_t          ovl_pix, bar_pix, sel_pix, pix_q;
  logic [IW-1:0] bar_idx;
  logic          act_q, hs_q, vs_q, vld_q;

  ovl_palette u_ovl_pal (
    .rgb      (ovl_rgb),
    .csel_rgb (csel_rgb),
    .pix      (ovl_pix)
  );

  cbar_locator #(.HPOS_W(HPOS_W), .NUM_BARS(NUM_BARS)) u_cbar_loc (
    .hpos      (in_hpos),
    .act_width (act_width),
    .bar_idx   (bar_idx)
  );

  cbar_shade #(.NUM_BARS(NUM_BARS)) u_cbar_shade (
    .bar_idx  (bar_idx),
    .csel_rgb (csel_rgb),
    .pix      (bar_pix)
  );

  // next-state selection: bars beat overlay, blanking always passes
  always_comb begin
    sel_pix = '{c0: in_c0, c1: in_c1, c2: in_c2};
    if (in_active) begin
      if (cbar_en)     sel_pix = bar_pix;
      else if (ovl_en) sel_pix = ovl_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pix_q <= '0;
      act_q <= 1'b0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else if (in_valid) begin
      pix_q <= sel_pix;
      act_q <= in_active;
      hs_q  <= in_hsync;
      vs_q  <= in_vsync;
    end
  end

  assign out_valid  = vld_q;
  assign out_active = act_q;
  assign out_hsync  = hs_q;
  assign out_vsync  = vs_q;
  assign out_c0     = pix_q.c0;
  assign out_c1     = pix_q.c1;
  assign out_c2     = pix_q.c2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R2
  AST_FLAGS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (out_hsync == $past(in_hsync)) && (out_vsync == $past(in_vsync))); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_c0) && $stable(out_c1) && $stable(out_c2)); // R3
  AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_active) |=> (out_c0 == $past(in_c0)) && (out_c1 == $past(in_c1))
                                 && (out_c2 == $past(in_c2))); // R5
  AST_BAR_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_active && cbar_en && !csel_rgb) |=>
      (out_c1 == 10'(LVL_MID)) && (out_c2 == 10'(LVL_MID))); // R9
endmodule

// File: tb/ovl_cbar_mixer_tb_top.sv
module ovl_cbar_mixer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12;

  logic clk, rst_n;
  logic in_valid, in_active, in_hsync, in_vsync;
  logic [HW-1:0] in_hpos, act_width;
  logic [9:0] in_c0, in_c1, in_c2;
  logic [2:0] ovl_rgb;
  logic ovl_en, cbar_en, csel_rgb;
  logic out_valid, out_active, out_hsync, out_vsync;
  logic [9:0] out_c0, out_c1, out_c2;

  ovl_cbar_mixer #(.HPOS_W(HW), .NUM_BARS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_active(in_active),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .in_hpos(in_hpos),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .ovl_rgb(ovl_rgb),
    .ovl_en(ovl_en), .cbar_en(cbar_en), .csel_rgb(csel_rgb),
    .act_width(act_width), .out_valid(out_valid), .out_active(out_active),
    .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  typedef struct {
    logic       v, a, hs, vs;
    logic [9:0] c0, c1, c2;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_e;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] lvl_of(input int k);
    case (k)
      0: return 10'd283;
      1: return 10'd502;
      2: return 10'd721;
      default: return 10'd940;
    endcase
  endfunction

  function automatic void yuv_ovl(input logic [2:0] c, output logic [9:0] y,
                                  output logic [9:0] u, output logic [9:0] v);
    case (c)
      3'd0: begin y = 64;  u = 512; v = 512; end
      3'd1: begin y = 164; u = 960; v = 440; end
      3'd2: begin y = 580; u = 216; v = 136; end
      3'd3: begin y = 680; u = 664; v = 64;  end
      3'd4: begin y = 324; u = 360; v = 960; end
      3'd5: begin y = 424; u = 808; v = 888; end
      3'd6: begin y = 840; u = 64;  v = 584; end
      default: begin y = 940; u = 512; v = 512; end
    endcase
  endfunction

  task automatic drive(input logic v, input logic a, input logic hs, input logic vs,
                       input int hp, input int d0, input int d1, input int d2,
                       input logic [2:0] col, input logic oe, input logic be,
                       input logic rgbm, input int aw, input string tag);
    exp_t e;
    int k;
    @(negedge clk);
    in_valid = v; in_active = a; in_hsync = hs; in_vsync = vs;
    in_hpos = HW'(hp); in_c0 = 10'(d0); in_c1 = 10'(d1); in_c2 = 10'(d2);
    ovl_rgb = col; ovl_en = oe; cbar_en = be; csel_rgb = rgbm; act_width = HW'(aw);
    e = last_e;
    e.tag = tag;
    e.v = v;
    if (v) begin
      e.a = a; e.hs = hs; e.vs = vs;
      e.c0 = 10'(d0); e.c1 = 10'(d1); e.c2 = 10'(d2);
      if (a && be) begin
        k = (aw == 0) ? 3 : (hp * 4) / aw;
        if (k > 3) k = 3;
        e.c0 = lvl_of(k);
        e.c1 = rgbm ? lvl_of(k) : 10'd512;
        e.c2 = rgbm ? lvl_of(k) : 10'd512;
      end else if (a && oe) begin
        if (rgbm) begin
          e.c0 = col[1] ? 10'd940 : 10'd64;
          e.c1 = col[0] ? 10'd940 : 10'd64;
          e.c2 = col[2] ? 10'd940 : 10'd64;
        end else begin
          yuv_ovl(col, e.c0, e.c1, e.c2);
        end
      end
    end
    last_e = e;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 1, 1, 1, 7, 999, 1, 2, 3'd7, 1, 1, 0, 10, "R3");
  endtask

  // monitor: compares one item per clock, sampled 1 ns after the edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({out_valid, out_active, out_hsync, out_vsync, out_c0, out_c1, out_c2} !==
          {e.v, e.a, e.hs, e.vs, e.c0, e.c1, e.c2}) begin
        errors++;
        $display("FAIL %s: got v=%b a=%b hs=%b vs=%b %0d/%0d/%0d exp v=%b a=%b hs=%b vs=%b %0d/%0d/%0d",
                 e.tag, out_valid, out_active, out_hsync, out_vsync, out_c0, out_c1, out_c2,
                 e.v, e.a, e.hs, e.vs, e.c0, e.c1, e.c2);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    last_e = '{v: 0, a: 0, hs: 0, vs: 0, c0: 0, c1: 0, c2: 0, tag: "R1"};
    rst_n = 0; in_valid = 0; in_active = 0; in_hsync = 0; in_vsync = 0;
    in_hpos = '0; in_c0 = 0; in_c1 = 0; in_c2 = 0; ovl_rgb = 0;
    ovl_en = 0; cbar_en = 0; csel_rgb = 0; act_width = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_valid, out_active, out_hsync, out_vsync, out_c0, out_c1, out_c2} !== '0) begin
      errors++;
      $display("FAIL R1: outputs %b %0d/%0d/%0d exp all zero", out_valid, out_c0, out_c1, out_c2);
    end
    idle(2); // R1 hold of reset values, R3

    // R4, R2: pass-through with sync flags
    drive(1, 1, 1, 0, 0, 100, 200, 300, 3'd5, 0, 0, 0, 40, "R4");
    drive(1, 1, 0, 1, 1, 1023, 0, 77, 3'd2, 0, 0, 1, 40, "R2");
    drive(1, 0, 1, 1, 2, 5, 6, 7, 3'd0, 0, 0, 0, 40, "R2");
    idle(1);

    // R7, R11: YCbCr overlay, enable toggling per pixel
    for (int c = 0; c < 8; c++) begin
      drive(1, 1, 0, 0, c, 111, 222, 333, 3'(c), 1, 0, 0, 40, "R7");
      drive(1, 1, 0, 0, c, 400 + c, 500, 600, 3'(c), 0, 0, 0, 40, "R11");
    end
    // R6: RGB overlay lane mapping
    for (int c = 0; c < 8; c++) drive(1, 1, 0, 0, c, 10, 20, 30, 3'(c), 1, 0, 1, 40, "R6");
    idle(2);

    // R5: blanking ignores enables
    drive(1, 0, 1, 0, 3, 64, 512, 512, 3'd4, 1, 1, 0, 40, "R5");
    drive(1, 0, 0, 1, 30, 900, 100, 50, 3'd1, 1, 0, 1, 40, "R5");

    // R8, R9: bar regions, edges, clamp, zero width
    begin
      int hps [11] = '{0, 24, 25, 49, 50, 74, 75, 99, 100, 150, 4095};
      foreach (hps[i]) drive(1, 1, 0, 0, hps[i], 1, 2, 3, 3'd0, 0, 1, 0, 100, "R8");
      foreach (hps[i]) drive(1, 1, 0, 0, hps[i], 1, 2, 3, 3'd0, 0, 1, 1, 100, "R9");
    end
    drive(1, 1, 0, 0, 0, 1, 2, 3, 3'd0, 0, 1, 0, 0, "R8");
    drive(1, 1, 0, 0, 2, 1, 2, 3, 3'd0, 0, 1, 0, 7, "R8");
    drive(1, 1, 0, 0, 5, 1, 2, 3, 3'd0, 0, 1, 1, 7, "R9");

    // R10: bars win over overlay
    drive(1, 1, 0, 0, 10, 9, 9, 9, 3'd6, 1, 1, 0, 40, "R10");
    drive(1, 1, 0, 0, 35, 9, 9, 9, 3'd1, 1, 1, 1, 40, "R10");
    idle(3);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R2: %0d results never compared", exp_q.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule